// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is the clocked front end of a synchronous burst static RAM, with a small storage array sized by parameters. On every rising clock edge it captures the word address and all control inputs. A burst opens with one of two address strobes. The strobe for the processor side is honoured only while the primary chip enable is high. The strobe for the cache controller is always honoured. The strobe cycle itself is the first access of the burst.

After a burst opens, the upper address bits stay fixed in a register. The lowest two bits come from an internal 2-bit counter. That counter steps only in cycles where the advance input is high, so cycles without advance repeat the same word. A mode input, sampled when the burst opens, selects one of two orders. In linear order the counter adds to the start offset and wraps modulo 4. In interleaved order it is XORed with the start offset.

Every access cycle is either a write or a read. A cycle is a write when the global write input is high, which writes every byte lane. It is also a write when the byte-write qualifier is high and at least one lane enable is set, which writes only the enabled lanes. Write data is taken at the same edge as the address, so no external write pulse is needed. A read returns the word one cycle later on `rdata`, and `rvalid` is high in that cycle while `oe` is high. The read return has no back-pressure: a word is offered for one cycle only and must be taken then. A power-down input stops all accesses and holds the burst state.

Top module: `sbsram_core`

## Requirements
- R1: After reset, `rvalid` is 0. No burst is open, so a cycle without a strobe performs no access and `rvalid` stays 0.
- R2: A read access at address A drives the stored word at A on `rdata` one clock edge later, with `rvalid`=1 while `oe`=1.
- R3: `oe`=0 forces `rvalid` to 0 and leaves the registered `rdata` intact. Raising `oe` again shows the same word with `rvalid`=1.
- R4: With `order_lin`=1 at the strobe, the burst addresses are start, then upper bits unchanged with low bits (start+1), (start+2), (start+3) modulo 4. The fifth address is the start again. For example, 0x35 gives 0x35, 0x36, 0x37, 0x34, 0x35.
- R5: With `order_lin`=0 at the strobe, the low bits of the k-th burst address are the start low bits XOR k. For example, 0x35 gives 0x35, 0x34, 0x37, 0x36.
- R6: In a continuation cycle with `advance`=0, the access uses the same address as the previous access.
- R7: While `ce_prim`=0, `strobe_cpu` is ignored. An open burst continues at its next address, and with no open burst no access occurs.
- R8: `strobe_ctl` is accepted even when `ce_prim`=0. With the device not selected, it closes the burst and performs no access, and later continuation cycles perform no access.
- R9: A strobe selects the device only when `ce_prim`=1, `ce_aux`=1 and `ce_block`=0. A strobe with any other combination performs no access and closes the burst.
- R10: With `wr_byte_en`=1, only lanes whose `lane_we` bit is 1 are written. Lane i is `wdata[8i+7:8i]`. With `wr_byte_en`=0 and `wr_all`=0, the lane enables have no effect and the cycle is a read.
- R11: `wr_all`=1 writes all four lanes whatever `wr_byte_en` and `lane_we` are.
- R12: A write in a strobe cycle goes to the strobe address. A write in a continuation cycle goes to the burst address. A write cycle gives `rvalid`=0 on the next cycle.
- R13: While `sleep`=1, no access occurs: no write, and `rvalid`=0 on the next cycle. Strobes are ignored and the burst state is held, so the burst resumes at its next address afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Power-down; blocks all accesses |
| ce_prim | input | 1 | Primary chip enable, active high; also gates `strobe_cpu` |
| ce_aux | input | 1 | Second chip enable, active high |
| ce_block | input | 1 | Third chip enable, must be low to select |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step the burst counter in a continuation cycle |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| wr_all | input | 1 | Global write of all lanes |
| wr_byte_en | input | 1 | Qualifier for per-lane writes |
| lane_we | input | LANES | Per-lane write enables |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable, gates `rvalid` |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench targets the burst orders from an odd start offset. At that offset linear and interleaved sequences differ, so a design that swapped or confused them returns the wrong words. It also targets the wrap after four steps, which a design with a wider counter would carry into the upper address bits. It drives the processor strobe with the primary enable low, both during a burst and outside one. A design that obeyed the strobe there would jump to the strobe address or return a spurious word. A design that blocked the controller strobe the same way would let a burst run past a deselect. Further cases are byte writes with and without the qualifier, where a design that ignored the qualifier would corrupt lanes, and strobes during power-down. A leaky design would write or would lose the burst position.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } order_t;

  // low two address bits for burst step 'step' from start offset 'start'
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input order_t     ord);
    logic [1:0] r;
    if (ord == ORD_LINEAR) r = start + step;
    else                   r = start ^ step;
    return r;
  endfunction
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce_prim,
  input  logic              ce_aux,
  input  logic              ce_block,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              burst_on
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      cnt;
  order_t          ord_q;

  logic       load;
  logic       picked;
  logic [1:0] eff_cnt;

  // processor strobe is blocked by the primary enable, controller strobe is not
  assign load    = strobe_ctl | (strobe_cpu & ce_prim);
  assign picked  = ce_prim & ce_aux & ~ce_block;
  assign eff_cnt = load ? 2'd0 : cnt + {1'b0, advance};

  always_comb begin
    acc_en   = 1'b0;
    acc_addr = addr;
    if (!sleep) begin
      if (load) begin
        acc_en   = picked;
        acc_addr = addr;
      end else begin
        acc_en   = burst_on;
        acc_addr = {base_hi, burst_lo(base_lo, eff_cnt, ord_q)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      base_hi  <= '0;
      base_lo  <= '0;
      cnt      <= '0;
      ord_q    <= ORD_INTLV;
    end else if (!sleep) begin
      if (load) begin
        burst_on <= picked;
        base_hi  <= addr[ADDR_W-1:2];
        base_lo  <= addr[1:0];
        cnt      <= 2'd0;
        ord_q    <= order_t'(order_lin);
      end else if (burst_on) begin
        cnt <= eff_cnt;
      end
    end
  end
endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes #(
  parameter int LANES = 4
) (
  input  logic             wr_all,
  input  logic             wr_byte_en,
  input  logic [LANES-1:0] lane_we,
  output logic [LANES-1:0] wr_lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_lanes[i] = wr_all | (wr_byte_en & lane_we[i]);
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    acc_en,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_cycle;
  assign rd_cycle = acc_en & ~(|wr_lanes);

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (acc_en && wr_lanes[i]) mem[acc_addr] <= wdata[i*LANE_W +: LANE_W];
      if (rd_cycle) rdata[i*LANE_W +: LANE_W] <= mem[acc_addr];
    end
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    ce_prim,
  input  logic                    ce_aux,
  input  logic                    ce_block,
  input  logic                    strobe_cpu,
  input  logic                    strobe_ctl,
  input  logic                    advance,
  input  logic                    order_lin,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_all,
  input  logic                    wr_byte_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              acc_en;
  logic [ADDR_W-1:0] acc_addr;
  logic              burst_on;
  logic [LANES-1:0]  wr_lanes;
  logic              rd_q;

  sbsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .ce_prim    (ce_prim),
    .ce_aux     (ce_aux),
    .ce_block   (ce_block),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .order_lin  (order_lin),
    .addr       (addr),
    .acc_en     (acc_en),
    .acc_addr   (acc_addr),
    .burst_on   (burst_on)
  );

  sbsram_lanes #(.LANES(LANES)) u_lanes (
    .wr_all     (wr_all),
    .wr_byte_en (wr_byte_en),
    .lane_we    (lane_we),
    .wr_lanes   (wr_lanes)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .acc_en   (acc_en),
    .acc_addr (acc_addr),
    .wr_lanes (wr_lanes),
    .wdata    (wdata[DATA_W-1:0]),
    .rdata    (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= acc_en & ~(|wr_lanes);
  end

  assign rvalid = rd_q & oe;
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              oe,
  input logic              rvalid,
  input logic              strobe_cpu,
  input logic              strobe_ctl,
  input logic              ce_prim,
  input logic              ce_aux,
  input logic              ce_block,
  input logic              advance,
  input logic              acc_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  wr_lanes,
  input logic              burst_on
);
  logic past_ok;
  logic strobe_taken;
  logic selected;

  assign strobe_taken = strobe_ctl | (strobe_cpu & ce_prim);
  assign selected     = ce_prim & ce_aux & ~ce_block;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_lanes == '0) |=> (rvalid == oe)); // R2

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(acc_en) && acc_en && !strobe_taken && !advance)
      |-> (acc_addr == $past(acc_addr))); // R6

  AST_BLOCKED_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu && !ce_prim && !strobe_ctl && !burst_on) |=> !rvalid); // R7

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_taken && !selected) |=> !rvalid); // R9

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_lanes != '0) |=> !rvalid); // R12

  AST_SLEEP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rvalid); // R13
endmodule

bind sbsram_core sbsram_core_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep      (sleep),
  .oe         (oe),
  .rvalid     (rvalid),
  .strobe_cpu (strobe_cpu),
  .strobe_ctl (strobe_ctl),
  .ce_prim    (ce_prim),
  .ce_aux     (ce_aux),
  .ce_block   (ce_block),
  .advance    (advance),
  .acc_en     (acc_en),
  .acc_addr   (acc_addr),
  .wr_lanes   (wr_lanes),
  .burst_on   (burst_on)
);

// File: tb/sbsram_core_test.sv
module sbsram_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep, ce_prim, ce_aux, ce_block;
  logic        strobe_cpu, strobe_ctl, advance, order_lin;
  logic [7:0]  addr;
  logic        wr_all, wr_byte_en;
  logic [3:0]  lane_we;
  logic [31:0] wdata;
  logic        oe;
  logic [31:0] rdata;
  logic        rvalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] refm [256];

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  sbsram_core uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_prim(ce_prim), .ce_aux(ce_aux),
    .ce_block(ce_block), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .advance(advance), .order_lin(order_lin), .addr(addr), .wr_all(wr_all),
    .wr_byte_en(wr_byte_en), .lane_we(lane_we), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5a, a + 8'd1};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    sleep = 0; ce_prim = 1; ce_aux = 1; ce_block = 0;
    strobe_cpu = 0; strobe_ctl = 0; advance = 0; order_lin = 1;
    addr = 0; wr_all = 0; wr_byte_en = 0; lane_we = 0; wdata = 0; oe = 1;
  endtask

  task automatic drive(input logic cpu, input logic ctl, input logic adv,
                       input logic [7:0] a);
    strobe_cpu = cpu; strobe_ctl = ctl; advance = adv; addr = a;
    tick();
    strobe_cpu = 0; strobe_ctl = 0; advance = 0;
  endtask

  task automatic check_read(input string req, input logic [7:0] a);
    checks++;
    if (rvalid !== 1'b1 || rdata !== refm[a]) begin
      errors++;
      $display("FAIL %s addr %h: rvalid=%b rdata=%h expected rvalid=1 rdata=%h",
               req, a, rvalid, rdata, refm[a]);
    end
  endtask

  task automatic check_none(input string req);
    checks++;
    if (rvalid !== 1'b0) begin
      errors++;
      $display("FAIL %s: rvalid=%b expected 0", req, rvalid);
    end
  endtask

  task automatic t_reset();
    check_none("R1 after reset");
    drive(0, 0, 1, 8'h00);
    check_none("R1 no burst open");
  endtask

  task automatic t_fill();
    for (int a = 0; a < 256; a++) begin
      wr_all = 1; wr_byte_en = 1; lane_we = 4'b0001; wdata = pat(8'(a));
      drive(0, 1, 0, 8'(a));
      refm[a] = pat(8'(a));
      if (a < 4) check_none("R12 write gives no valid");
    end
    wr_all = 0; wr_byte_en = 0; lane_we = 0;
    drive(0, 1, 0, 8'h03);
    check_read("R11 global write ignores lane enables", 8'h03);
  endtask

  task automatic t_linear();
    order_lin = 1;
    drive(1, 0, 0, 8'h35); check_read("R4 linear start", 8'h35);
    order_lin = 0;
    drive(0, 0, 1, 8'hF0); check_read("R4 linear step1", 8'h36);
    drive(0, 0, 1, 8'hF0); check_read("R4 linear step2", 8'h37);
    drive(0, 0, 1, 8'hF0); check_read("R4 linear wrap", 8'h34);
    drive(0, 0, 1, 8'hF0); check_read("R4 linear back to start", 8'h35);
    order_lin = 1;
  endtask

  task automatic t_interleave();
    order_lin = 0;
    drive(0, 1, 0, 8'h35); check_read("R5 interleave start", 8'h35);
    order_lin = 1;
    drive(0, 0, 1, 8'h00); check_read("R5 interleave step1", 8'h34);
    drive(0, 0, 1, 8'h00); check_read("R5 interleave step2", 8'h37);
    drive(0, 0, 1, 8'h00); check_read("R5 interleave step3", 8'h36);
  endtask

  task automatic t_hold();
    drive(0, 1, 0, 8'h80); check_read("R6 start", 8'h80);
    drive(0, 0, 0, 8'h11); check_read("R6 hold 1", 8'h80);
    drive(0, 0, 0, 8'h22); check_read("R6 hold 2", 8'h80);
    drive(0, 0, 1, 8'h33); check_read("R6 step after hold", 8'h81);
  endtask

  task automatic t_oe();
    oe = 0;
    drive(0, 1, 0, 8'h44);
    check_none("R3 oe low masks valid");
    oe = 1; #1;
    check_read("R3 data kept under oe", 8'h44);
    drive(0, 1, 0, 8'h45); check_read("R2 read latency", 8'h45);
  endtask

  task automatic t_cpu_blocked();
    drive(0, 1, 0, 8'h10); check_read("R7 burst start", 8'h10);
    ce_prim = 0;
    drive(1, 0, 1, 8'hF0); check_read("R7 cpu strobe ignored, burst goes on", 8'h11);
    ce_prim = 1;
  endtask

  task automatic t_ctl_open();
    ce_prim = 0;
    drive(0, 1, 0, 8'h18); check_none("R8 ctl strobe deselects");
    ce_prim = 1;
    drive(0, 0, 1, 8'h00); check_none("R8 burst closed");
    ce_prim = 0;
    drive(1, 0, 0, 8'h18); check_none("R7 cpu strobe ignored with no burst");
    ce_prim = 1;
  endtask

  task automatic t_select();
    for (int v = 0; v < 8; v++) begin
      if (v != 3'b110) begin
        {ce_prim, ce_aux, ce_block} = 3'(v);
        drive(0, 1, 0, 8'h20);
        check_none($sformatf("R9 combination %03b", v));
      end
    end
    {ce_prim, ce_aux, ce_block} = 3'b110;
    drive(1, 0, 0, 8'h20); check_read("R9 selected", 8'h20);
  endtask

  task automatic t_bytes();
    wr_byte_en = 1; lane_we = 4'b0101; wdata = 32'hAABBCCDD;
    drive(0, 1, 0, 8'h50);
    refm[8'h50] = {refm[8'h50][31:24], 8'hBB, refm[8'h50][15:8], 8'hDD};
    check_none("R10 byte write cycle");
    wr_byte_en = 0; lane_we = 4'b1111; wdata = 32'h01020304;
    drive(0, 1, 0, 8'h51);
    check_read("R10 lane enables without qualifier read", 8'h51);
    lane_we = 0;
    drive(0, 1, 0, 8'h50); check_read("R10 only selected lanes changed", 8'h50);
    wr_all = 1; wdata = 32'h12345678;
    drive(0, 1, 0, 8'hC0); refm[8'hC0] = 32'h12345678;
    wr_all = 0;
    drive(0, 1, 0, 8'hC0); check_read("R11 global write", 8'hC0);
  endtask

  task automatic t_write_addr();
    drive(0, 1, 0, 8'h60); check_read("R12 burst start", 8'h60);
    wr_all = 1; wdata = 32'hCAFE0061;
    drive(0, 0, 1, 8'hEE); refm[8'h61] = 32'hCAFE0061;
    check_none("R12 continue write");
    wdata = 32'hBEEF0090;
    drive(1, 0, 0, 8'h90); refm[8'h90] = 32'hBEEF0090;
    wr_all = 0;
    drive(0, 1, 0, 8'h61); check_read("R12 continue write address", 8'h61);
    drive(0, 1, 0, 8'h62); check_read("R12 neighbour untouched", 8'h62);
    drive(0, 1, 0, 8'h90); check_read("R12 strobe write address", 8'h90);
  endtask

  task automatic t_sleep();
    drive(0, 1, 0, 8'h70); check_read("R13 burst start", 8'h70);
    sleep = 1; wr_all = 1; wdata = 32'hDEADBEEF;
    drive(0, 1, 1, 8'h00); check_none("R13 no access while asleep");
    sleep = 0; wr_all = 0;
    drive(0, 0, 1, 8'h00); check_read("R13 burst resumes", 8'h71);
    drive(0, 1, 0, 8'h00); check_read("R13 no write while asleep", 8'h00);
  endtask

  initial begin
    defaults();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_linear();
    t_interleave();
    t_hold();
    t_oe();
    t_cpu_blocked();
    t_ctl_open();
    t_select();
    t_bytes();
    t_write_addr();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: cycles=%0d expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule